// File: doc/BRIEF.md
# Nibble-Wide Host Register Interface for a Calendar Clock

This block sits between a 4-bit host bus and the counting core of a calendar clock. The host addresses sixteen 4-bit locations. Locations 0 to 12 are the calendar digits, which are held by the counter. Locations 13, 14 and 15 are three control registers that live inside this block. An address-latch strobe can capture the address and the active-low select, so the block can share a multiplexed bus. Tying that strobe high makes the address path transparent. A second, active-high select is not latched. Driving it low parks the interface and clears the freeze and sub-second-clear controls.

All bus pins are sampled synchronously on `clk`. A write takes effect when the write strobe returns high. A write to a digit location emits a one-cycle load strobe towards the counter, carrying the digit index and the masked data. Reads are combinational. While a read is enabled, `bus_doe` is high and `bus_dout` carries the addressed value. At all other times `bus_doe` is low, which stands for a high-impedance bus.

The control registers carry several special rules:
- A freeze bit and a busy indication form a handshake for safe digit access.
- An interrupt flag can be cleared by writing 0, and writing 1 to it has no effect.
- A self-clearing adjust request is cleared by the counter.
- The 12/24-hour selector only changes while the sub-second-clear bit is already set.

Top module: `nbr_host_if`

## Requirements
- R1: While `bus_ale` and `bus_cs1` are both high, the address and `bus_cs0_n` come straight from the pins. At any other time, the values captured at the last clock edge with both strobes high are used.
- R2: The block is selected only when `bus_cs1`=1 and the effective `bus_cs0_n`=0. When it is not selected, it neither drives the bus nor accepts a write.
- R3: A write commits in the first cycle that `bus_wr_n` is sampled high after being sampled low while selected. The new register state is visible from the next cycle. A commit to address 0..12 raises `ld_stb` for exactly one cycle after the commit edge, with `ld_idx` set to the address and `ld_data` set to the masked data.
- R4: `bus_doe`=1 exactly while the block is selected with `bus_rd_n`=0 and `bus_wr_n`=1. In that state `bus_dout` is the addressed value. At all other times `bus_dout`=0.
- R5: Digit bits that do not exist read as 0 and are loaded as 0. The valid-bit masks by index 0..12 are F,7,F,7,F,7,F,3,F,1,F,F,7 (hex). When the 24-hour bit is set, bit 2 of index 5 also reads as 0.
- R6: Register 13 contains freeze in bit 0, busy in bit 1, interrupt flag in bit 2 and adjust request in bit 3. Writing bit 2 = 0 clears the flag, and writing bit 2 = 1 leaves it unchanged. The busy bit ignores writes. An `irq_event` while `ctl_mask`=0 sets the flag, and this takes priority over a clear in the same cycle.
- R7: Busy reads 1 whenever freeze is 0. While freeze is 1, busy reads the level of `cnt_update`.
- R8: A clock edge with `bus_cs1`=0 clears `ctl_hold` and `ctl_clr_sub`.
- R9: Register 15 contains sub-second clear in bit 0, stop in bit 1, 24-hour in bit 2 and test in bit 3. The 24-hour bit takes a written value only if sub-second clear was already 1 before that write.
- R10: Writing 1 to the adjust bit sets `ctl_adj`. It stays set until an `adj_done` pulse clears it. Writing 0 to that bit has no effect.
- R11: Register 14 contains mask in bit 0, mode in bit 1 and period select in bits 3:2. All four bits are writable and read back as written.
- R12: If `bus_rd_n` and `bus_wr_n` are both low while selected, the bus stays undriven and the whole write pulse is discarded.
- R13: After reset, all control outputs are 0, `bus_doe`=0, and register 13 reads 4'b0010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ale | input | 1 | Address latch strobe, tie high for a plain bus |
| bus_cs0_n | input | 1 | Latched active-low select |
| bus_cs1 | input | 1 | Unlatched active-high select |
| bus_addr | input | 4 | Register address |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_din | input | 4 | Write data from host |
| bus_dout | output | 4 | Read data to host |
| bus_doe | output | 1 | Data bus drive enable (low = high impedance) |
| cnt_digits | input | 52 | Thirteen calendar digits from the counter, index 0 in the low nibble |
| cnt_update | input | 1 | Counter carry update in progress |
| irq_event | input | 1 | Periodic interrupt timing pulse |
| adj_done | input | 1 | Counter finished the 30-second adjust |
| ld_stb | output | 1 | Digit load strobe |
| ld_idx | output | 4 | Digit index to load |
| ld_data | output | 4 | Masked digit value to load |
| ctl_hold | output | 1 | Freeze carries into the seconds |
| ctl_irq | output | 1 | Interrupt flag |
| ctl_adj | output | 1 | 30-second adjust request |
| ctl_mask | output | 1 | Interrupt output mask |
| ctl_irq_mode | output | 1 | 1 = latched interrupt, 0 = fixed-cycle pulse |
| ctl_period | output | 2 | Interrupt period select |
| ctl_clr_sub | output | 1 | Clear sub-second counter |
| ctl_stop | output | 1 | Stop counting |
| ctl_h24 | output | 1 | 24-hour mode |
| ctl_test | output | 1 | Test mode |

## Verification
Read data and the drive enable are combinational from the pins, the address latch and the register state. The bench therefore samples them 1 ns after it changes the strobes at a falling clock edge.

A write commits at the rising edge where the high write strobe is first seen. Both the load strobe and the new register contents appear after that edge, so the bench checks them at the following falling edge.

The effects of `bus_cs1` going low, of `irq_event` and of `adj_done` each need one rising edge. The bench holds each of these stimuli across exactly one edge, then reads the result back through the bus.

// File: rtl/nbr_pkg.sv
package nbr_pkg;
  localparam int NIB        = 4;
  localparam int NUM_DIGITS = 13;
  localparam logic [3:0] ADDR_CTLD = 4'd13;
  localparam logic [3:0] ADDR_CTLE = 4'd14;
  localparam logic [3:0] ADDR_CTLF = 4'd15;
  localparam logic [3:0] IDX_HOUR_TENS = 4'd5;

  typedef struct packed {
    logic test;
    logic h24;
    logic stop;
    logic clr_sub;
  } regf_t;

  typedef struct packed {
    logic [1:0] period;
    logic       mode;
    logic       mask;
  } rege_t;

  // valid bits of each calendar digit
  function automatic logic [3:0] digit_mask(input logic [3:0] idx);
    case (idx)
      4'd1, 4'd3, 4'd5, 4'd12: digit_mask = 4'h7;
      4'd7:                    digit_mask = 4'h3;
      4'd9:                    digit_mask = 4'h1;
      default:                 digit_mask = 4'hF;
    endcase
  endfunction
endpackage

// File: rtl/nbr_bus_front.sv
module nbr_bus_front #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_ale,
  input  logic          bus_cs0_n,
  input  logic          bus_cs1,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd_n,
  input  logic          bus_wr_n,
  output logic [AW-1:0] addr_eff,
  output logic          rd_en,
  output logic          commit
);
  logic          ale_eff, cs0n_eff, sel, wr_low, rd_low, conflict;
  logic [AW-1:0] addr_q;
  logic          cs0n_q, wr_act_q, bad_q;
  logic          bad_d;

  always_comb begin
    ale_eff  = bus_ale & bus_cs1;
    addr_eff = ale_eff ? bus_addr  : addr_q;
    cs0n_eff = ale_eff ? bus_cs0_n : cs0n_q;
    sel      = bus_cs1 & ~cs0n_eff;
    wr_low   = sel & ~bus_wr_n;
    rd_low   = sel & ~bus_rd_n;
    conflict = wr_low & rd_low;
    rd_en    = rd_low & bus_wr_n;
    commit   = wr_act_q & sel & bus_wr_n & ~bad_q;
    bad_d    = wr_low ? (bad_q | conflict) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      cs0n_q   <= 1'b1;
      wr_act_q <= 1'b0;
      bad_q    <= 1'b0;
    end else begin
      if (ale_eff) begin
        addr_q <= bus_addr;
        cs0n_q <= bus_cs0_n;
      end
      wr_act_q <= wr_low;
      bad_q    <= bad_d;
    end
  end
endmodule

// File: rtl/nbr_ctrl_regs.sv
module nbr_ctrl_regs
  import nbr_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_cs1,
  input  logic          commit,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          irq_event,
  input  logic          adj_done,
  output logic          hold,
  output logic          irq,
  output logic          adj,
  output rege_t         rege,
  output regf_t         regf,
  output logic          ld_stb,
  output logic [AW-1:0] ld_idx,
  output logic [DW-1:0] ld_data
);
  logic          hold_d, irq_d, adj_d, ld_d;
  rege_t         e_d;
  regf_t         f_d;
  logic [AW-1:0] idx_d;
  logic [DW-1:0] dat_d;

  always_comb begin
    hold_d = hold;
    irq_d  = irq;
    adj_d  = adj;
    e_d    = rege;
    f_d    = regf;
    ld_d   = 1'b0;
    idx_d  = ld_idx;
    dat_d  = ld_data;
    if (adj_done) adj_d = 1'b0;
    if (commit) begin
      if (waddr < AW'(NUM_DIGITS)) begin
        ld_d  = 1'b1;
        idx_d = waddr;
        dat_d = wdata & digit_mask(waddr);
      end else if (waddr == ADDR_CTLD) begin
        hold_d = wdata[0];
        if (!wdata[2]) irq_d = 1'b0;
        if (wdata[3])  adj_d = 1'b1;
      end else if (waddr == ADDR_CTLE) begin
        e_d = rege_t'(wdata);
      end else begin
        f_d.clr_sub = wdata[0];
        f_d.stop    = wdata[1];
        f_d.test    = wdata[3];
        if (regf.clr_sub) f_d.h24 = wdata[2];
      end
    end
    if (irq_event && !rege.mask) irq_d = 1'b1;
    if (!bus_cs1) begin
      hold_d      = 1'b0;
      f_d.clr_sub = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold    <= 1'b0;
      irq     <= 1'b0;
      adj     <= 1'b0;
      rege    <= '0;
      regf    <= '0;
      ld_stb  <= 1'b0;
      ld_idx  <= '0;
      ld_data <= '0;
    end else begin
      hold    <= hold_d;
      irq     <= irq_d;
      adj     <= adj_d;
      rege    <= e_d;
      regf    <= f_d;
      ld_stb  <= ld_d;
      ld_idx  <= idx_d;
      ld_data <= dat_d;
    end
  end
endmodule

// File: rtl/nbr_read_mux.sv
module nbr_read_mux
  import nbr_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 4
) (
  input  logic                     rd_en,
  input  logic [AW-1:0]            addr,
  input  logic [NUM_DIGITS*DW-1:0] digits,
  input  logic                     cnt_update,
  input  logic                     hold,
  input  logic                     irq,
  input  logic                     adj,
  input  rege_t                    rege,
  input  regf_t                    regf,
  output logic [DW-1:0]            dout
);
  logic [DW-1:0] dig_view [NUM_DIGITS];
  logic [DW-1:0] rdata;
  logic          busy;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_view
    logic [DW-1:0] msk;
    always_comb begin
      msk = digit_mask(AW'(g));
      if (AW'(g) == IDX_HOUR_TENS && regf.h24) msk[2] = 1'b0;
      dig_view[g] = digits[g*DW +: DW] & msk;
    end
  end

  always_comb begin
    busy = ~hold | cnt_update;
    if (addr < AW'(NUM_DIGITS))  rdata = dig_view[addr];
    else if (addr == ADDR_CTLD)  rdata = {adj, irq, busy, hold};
    else if (addr == ADDR_CTLE)  rdata = rege;
    else                         rdata = regf;
    dout = rd_en ? rdata : '0;
  end
endmodule

// File: rtl/nbr_host_if.sv
module nbr_host_if
  import nbr_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 4,
  localparam int DIGW = NUM_DIGITS * DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_ale,
  input  logic            bus_cs0_n,
  input  logic            bus_cs1,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_rd_n,
  input  logic            bus_wr_n,
  input  logic [DW-1:0]   bus_din,
  output logic [DW-1:0]   bus_dout,
  output logic            bus_doe,
  input  logic [DIGW-1:0] cnt_digits,
  input  logic            cnt_update,
  input  logic            irq_event,
  input  logic            adj_done,
  output logic            ld_stb,
  output logic [AW-1:0]   ld_idx,
  output logic [DW-1:0]   ld_data,
  output logic            ctl_hold,
  output logic            ctl_irq,
  output logic            ctl_adj,
  output logic            ctl_mask,
  output logic            ctl_irq_mode,
  output logic [1:0]      ctl_period,
  output logic            ctl_clr_sub,
  output logic            ctl_stop,
  output logic            ctl_h24,
  output logic            ctl_test
);
  logic [AW-1:0] addr_eff;
  logic          rd_en, commit;
  rege_t         rege;
  regf_t         regf;

  nbr_bus_front #(.AW(AW)) u_front (
    .clk(clk), .rst_n(rst_n), .bus_ale(bus_ale), .bus_cs0_n(bus_cs0_n),
    .bus_cs1(bus_cs1), .bus_addr(bus_addr), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .addr_eff(addr_eff), .rd_en(rd_en), .commit(commit)
  );

  nbr_ctrl_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_cs1(bus_cs1), .commit(commit),
    .waddr(addr_eff), .wdata(bus_din), .irq_event(irq_event),
    .adj_done(adj_done), .hold(ctl_hold), .irq(ctl_irq), .adj(ctl_adj),
    .rege(rege), .regf(regf), .ld_stb(ld_stb), .ld_idx(ld_idx),
    .ld_data(ld_data)
  );

  nbr_read_mux #(.AW(AW), .DW(DW)) u_rmux (
    .rd_en(rd_en), .addr(addr_eff), .digits(cnt_digits),
    .cnt_update(cnt_update), .hold(ctl_hold), .irq(ctl_irq), .adj(ctl_adj),
    .rege(rege), .regf(regf), .dout(bus_dout)
  );

  assign bus_doe      = rd_en;
  assign ctl_mask     = rege.mask;
  assign ctl_irq_mode = rege.mode;
  assign ctl_period   = rege.period;
  assign ctl_clr_sub  = regf.clr_sub;
  assign ctl_stop     = regf.stop;
  assign ctl_h24      = regf.h24;
  assign ctl_test     = regf.test;
endmodule

// File: rtl/nbr_host_if_chk.sv
module nbr_host_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_cs1,
  input logic       bus_rd_n,
  input logic       bus_wr_n,
  input logic       bus_doe,
  input logic [3:0] bus_dout,
  input logic [3:0] rd_addr,
  input logic       ctl_hold,
  input logic       ctl_clr_sub,
  input logic       ctl_h24,
  input logic       ctl_mask,
  input logic       ctl_irq,
  input logic       irq_event,
  input logic       ld_stb
);
  p_drive_qual_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> (bus_cs1 && !bus_rd_n && bus_wr_n));

  p_quiet_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_doe |-> (bus_dout == 4'h0));

  p_busy_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_doe && rd_addr == 4'hD && !ctl_hold) |-> bus_dout[1]);

  p_cs1_park_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cs1 |=> (!ctl_hold && !ctl_clr_sub));

  p_h24_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_clr_sub |=> $stable(ctl_h24));

  p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_event && !ctl_mask) |=> ctl_irq);

  p_load_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb |=> !ld_stb);
endmodule

bind nbr_host_if nbr_host_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_cs1(bus_cs1), .bus_rd_n(bus_rd_n),
  .bus_wr_n(bus_wr_n), .bus_doe(bus_doe), .bus_dout(bus_dout),
  .rd_addr(addr_eff), .ctl_hold(ctl_hold), .ctl_clr_sub(ctl_clr_sub),
  .ctl_h24(ctl_h24), .ctl_mask(ctl_mask), .ctl_irq(ctl_irq),
  .irq_event(irq_event), .ld_stb(ld_stb)
);

// File: tb/tb_nbr_host_if.sv
module tb_nbr_host_if;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_ale = 1'b1, bus_cs0_n = 1'b0, bus_cs1 = 1'b1;
  logic [3:0]  bus_addr = '0, bus_din = '0;
  logic        bus_rd_n = 1'b1, bus_wr_n = 1'b1;
  logic [3:0]  bus_dout;
  logic        bus_doe;
  logic [51:0] cnt_digits = '0;
  logic        cnt_update = 1'b0, irq_event = 1'b0, adj_done = 1'b0;
  logic        ld_stb;
  logic [3:0]  ld_idx, ld_data;
  logic        ctl_hold, ctl_irq, ctl_adj, ctl_mask, ctl_irq_mode;
  logic [1:0]  ctl_period;
  logic        ctl_clr_sub, ctl_stop, ctl_h24, ctl_test;

  int checks = 0;
  int errors = 0;

  // bench model of register state
  logic m_hold = 0, m_irq = 0, m_adj = 0;
  logic [3:0] m_e = 0;
  logic m_clr = 0, m_stop = 0, m_h24 = 0, m_test = 0;
  logic g_stb;
  logic [3:0] g_idx, g_dat, rv;
  logic roe;

  always #(CLK_PERIOD/2) clk = ~clk;

  nbr_host_if dut (
    .clk(clk), .rst_n(rst_n), .bus_ale(bus_ale), .bus_cs0_n(bus_cs0_n),
    .bus_cs1(bus_cs1), .bus_addr(bus_addr), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_din(bus_din), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .cnt_digits(cnt_digits), .cnt_update(cnt_update),
    .irq_event(irq_event), .adj_done(adj_done), .ld_stb(ld_stb),
    .ld_idx(ld_idx), .ld_data(ld_data), .ctl_hold(ctl_hold),
    .ctl_irq(ctl_irq), .ctl_adj(ctl_adj), .ctl_mask(ctl_mask),
    .ctl_irq_mode(ctl_irq_mode), .ctl_period(ctl_period),
    .ctl_clr_sub(ctl_clr_sub), .ctl_stop(ctl_stop), .ctl_h24(ctl_h24),
    .ctl_test(ctl_test)
  );

  function automatic logic [3:0] valid_bits(input int idx);
    case (idx)
      1, 3, 5, 12: return 4'h7;
      7:           return 4'h3;
      9:           return 4'h1;
      default:     return 4'hF;
    endcase
  endfunction

  function automatic logic [3:0] exp_read(input logic [3:0] a);
    logic [3:0] m;
    if (a < 4'd13) begin
      m = valid_bits(int'(a));
      if (a == 4'd5 && m_h24) m[2] = 1'b0;
      return cnt_digits[a*4 +: 4] & m;
    end
    if (a == 4'd13) return {m_adj, m_irq, ~m_hold | cnt_update, m_hold};
    if (a == 4'd14) return m_e;
    return {m_test, m_h24, m_stop, m_clr};
  endfunction

  task automatic model_write(input logic [3:0] a, input logic [3:0] d);
    if (a == 4'd13) begin
      m_hold = d[0];
      if (!d[2]) m_irq = 1'b0;
      if (d[3])  m_adj = 1'b1;
    end else if (a == 4'd14) begin
      m_e = d;
    end else if (a == 4'd15) begin
      if (m_clr) m_h24 = d[2];
      m_clr = d[0]; m_stop = d[1]; m_test = d[3];
    end
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    bus_addr = a; bus_din = d; bus_wr_n = 1'b0;
    @(negedge clk);
    bus_wr_n = 1'b1;
    @(negedge clk);
    g_stb = ld_stb; g_idx = ld_idx; g_dat = ld_data;
  endtask

  task automatic bus_rd(input logic [3:0] a);
    @(negedge clk);
    bus_addr = a; bus_rd_n = 1'b0;
    #1;
    rv = bus_dout; roe = bus_doe;
    @(negedge clk);
    bus_rd_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 13; i++) cnt_digits[i*4 +: 4] = 4'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    chk("R13 controls", {ctl_hold, ctl_irq, ctl_adj, ctl_clr_sub}, 4'h0);
    chk("R13 controls2", {ctl_mask, ctl_irq_mode, ctl_stop, ctl_h24}, 4'h0);
    chk("R13 idle doe", {3'b0, bus_doe}, 4'h0);
    bus_rd(4'd13);
    chk("R13 reg13 reset", rv, 4'b0010);

    // R11 / R4 basic
    bus_wr(4'd14, 4'hA); model_write(4'd14, 4'hA);
    bus_rd(4'd14);
    chk("R11 reg14 readback", rv, 4'hA);
    chk("R4 drive enable", {3'b0, roe}, 4'h1);
    chk("R11 period pins", {2'b0, ctl_period}, 4'h2);
    bus_wr(4'd14, 4'h0); model_write(4'd14, 4'h0);

    // R1 address latch: capture E then scramble pins with ALE low
    @(negedge clk);
    bus_ale = 1'b1; bus_addr = 4'd14; bus_cs0_n = 1'b0;
    @(negedge clk);
    bus_ale = 1'b0; bus_addr = 4'd0; bus_cs0_n = 1'b1;
    bus_wr(4'd3, 4'h6); model_write(4'd14, 4'h6);
    bus_addr = 4'd3;
    bus_rd(4'd3);
    chk("R1 latched address write/read", rv, 4'h6);
    @(negedge clk);
    bus_ale = 1'b1; bus_cs0_n = 1'b1;
    // R2 deselected: no drive, no write
    bus_wr(4'd14, 4'h9);
    chk("R2 no load strobe", {3'b0, g_stb}, 4'h0);
    bus_rd(4'd14);
    chk("R2 no drive", {3'b0, roe}, 4'h0);
    chk("R4 dout zero when idle", rv, 4'h0);
    @(negedge clk);
    bus_cs0_n = 1'b0;
    bus_rd(4'd14);
    chk("R2 write ignored when deselected", rv, 4'h6);

    // R12 RD and WR both low
    @(negedge clk);
    bus_addr = 4'd14; bus_din = 4'hF; bus_wr_n = 1'b0; bus_rd_n = 1'b0;
    #1;
    chk("R12 bus undriven", {3'b0, bus_doe}, 4'h0);
    @(negedge clk);
    bus_rd_n = 1'b1;
    @(negedge clk);
    bus_wr_n = 1'b1;
    @(negedge clk);
    bus_rd(4'd14);
    chk("R12 write discarded", rv, 4'h6);

    // R9 guarded 24h bit
    bus_wr(4'd15, 4'h4); model_write(4'd15, 4'h4);
    chk("R9 h24 blocked while clr_sub=0", {3'b0, ctl_h24}, 4'h0);
    bus_wr(4'd15, 4'h1); model_write(4'd15, 4'h1);
    bus_wr(4'd15, 4'h4); model_write(4'd15, 4'h4);
    chk("R9 h24 taken after clr_sub=1", {3'b0, ctl_h24}, 4'h1);
    bus_rd(4'd5);
    chk("R5 hour-tens bit2 hidden in 24h", rv, exp_read(4'd5));

    // R7 busy handshake
    bus_wr(4'd13, 4'h5); model_write(4'd13, 4'h5);
    @(negedge clk); cnt_update = 1'b1;
    bus_rd(4'd13);
    chk("R7 busy during update", rv, exp_read(4'd13));
    @(negedge clk); cnt_update = 1'b0;
    bus_rd(4'd13);
    chk("R7 busy clear with freeze", rv, exp_read(4'd13));

    // R8 cs1 low parks freeze and clr_sub
    bus_wr(4'd15, 4'h5); model_write(4'd15, 4'h5);
    @(negedge clk); bus_cs1 = 1'b0;
    @(negedge clk); bus_cs1 = 1'b1;
    m_hold = 1'b0; m_clr = 1'b0;
    bus_rd(4'd13);
    chk("R8 freeze cleared", rv, exp_read(4'd13));
    bus_rd(4'd15);
    chk("R8 clr_sub cleared", rv, exp_read(4'd15));

    // R6 interrupt flag
    @(negedge clk); irq_event = 1'b1;
    @(negedge clk); irq_event = 1'b0; m_irq = 1'b1;
    bus_wr(4'd13, 4'h4); model_write(4'd13, 4'h4);
    bus_rd(4'd13);
    chk("R6 write 1 keeps flag", rv, exp_read(4'd13));
    bus_wr(4'd13, 4'h0); model_write(4'd13, 4'h0);
    bus_rd(4'd13);
    chk("R6 write 0 clears flag", rv, exp_read(4'd13));
    bus_wr(4'd14, 4'h1); model_write(4'd14, 4'h1);
    @(negedge clk); irq_event = 1'b1;
    @(negedge clk); irq_event = 1'b0;
    bus_rd(4'd13);
    chk("R6 masked event ignored", rv, exp_read(4'd13));
    bus_wr(4'd14, 4'h0); model_write(4'd14, 4'h0);

    // R10 adjust request
    bus_wr(4'd13, 4'hC); model_write(4'd13, 4'hC);
    chk("R10 adjust set", {3'b0, ctl_adj}, 4'h1);
    bus_wr(4'd13, 4'h4); model_write(4'd13, 4'h4);
    chk("R10 write 0 keeps adjust", {3'b0, ctl_adj}, 4'h1);
    @(negedge clk); adj_done = 1'b1;
    @(negedge clk); adj_done = 1'b0; m_adj = 1'b0;
    chk("R10 adjust cleared by done", {3'b0, ctl_adj}, 4'h0);

    // random mix, R3 R5 R4 R11 R9 R6
    for (int it = 0; it < 400; it++) begin
      logic [3:0] a, d, ra;
      a = 4'($urandom); d = 4'($urandom); ra = 4'($urandom);
      @(negedge clk); cnt_update = ($urandom % 4) == 0;
      bus_wr(a, d); model_write(a, d);
      if (a < 4'd13) begin
        chk("R3 load strobe", {3'b0, g_stb}, 4'h1);
        chk("R3 load index", g_idx, a);
        chk("R5 load data masked", g_dat, d & valid_bits(int'(a)));
      end else begin
        chk("R3 no strobe for control", {3'b0, g_stb}, 4'h0);
      end
      bus_rd(ra);
      chk("R4 random read", rv, exp_read(ra));
      chk("R4 random read drive", {3'b0, roe}, 4'h1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule